// File: doc/BRIEF.md
# Serial Configuration ROM Reader

This block fetches a run of configuration bytes from an external serial memory over a four-wire bus in clock mode 0, using a 24 MHz system clock. A single-cycle start request supplies a base address and a byte count. The block then lowers chip select and sends the read opcode followed by the address. It clocks the requested number of bytes in and hands each one to the consumer as a one-cycle valid strobe, together with the byte and its position in the run.

Two straps are captured while reset is held. The first says whether a memory is fitted at all. The second picks the address length: 24 bits for flash-type parts, or 16 bits for EEPROM-type parts. Every serial interval is a whole number of system cycles. The defaults assume a 24 MHz clock: a 2 MHz serial clock, at least 250 ns of chip-select setup and hold, and 500 ns of chip-select idle time between transfers. A busy level and a one-cycle done pulse frame each request.

Top module: `cfgrom_reader`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select is high, the serial clock is low, and busy, done and the byte-valid strobe are all low.
- R2: The serial clock rests low whenever chip select is high. The data-out line changes only on the cycle in which the serial clock falls, and never while it is high. Data-in is sampled on the cycle in which the serial clock rises.
- R3: Every serial clock high phase lasts exactly CLK_HALF system cycles (6 by default). Every low phase lasts at least CLK_HALF system cycles, giving one bit per 2*CLK_HALF cycles.
- R4: Chip select is low for at least CS_LEAD_CYC cycles before the first serial clock rise. It stays low for at least CS_LAG_CYC cycles after the last fall. Between transfers it stays high for at least CS_IDLE_CYC cycles.
- R5: The first 8 bits sent are the opcode 0x03, MSB first. The address follows, MSB first: all 24 bits of base_addr when the width strap was high, and only base_addr[15:0] as 16 bits when it was low.
- R6: After the header, exactly 8*byte_count further clocks are issued. Each received byte is assembled MSB first and presented with rd_valid high for one cycle, with rd_index counting 0 to byte_count-1 in order.
- R7: Busy rises in the cycle after an accepted start. Done is a one-cycle pulse at the end of the transfer, and busy is low in that same cycle.
- R8: If the use-ROM strap was low at reset, a start raises done in the next cycle. Chip select never falls and no serial clock edge occurs.
- R9: A start with byte_count of 0 raises done in the next cycle with no bus activity.
- R10: The straps are captured only while reset is held. Changing them after reset leaves the address length and the use-ROM choice unchanged.
- R11: A start while busy is ignored. The running transfer completes unchanged and only one done pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| strap_use_rom | input | 1 | High when a serial memory is fitted |
| strap_wide_addr | input | 1 | High for a 24-bit address, low for a 16-bit address |
| start | input | 1 | One-cycle transfer request |
| base_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Byte strobe |
| rd_data | output | 8 | Received byte |
| rd_index | output | CNT_W | Position of the byte in the run |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
The bound checker watches the bus on every cycle. It checks the serial clock phase lengths, the chip-select setup, hold and idle intervals, the data-out line holding still while the clock is high, the clock resting low with chip select high, and the framing of done, busy and the byte strobe. Some properties depend on bytes and can only be shown by the bench's scenarios, using a memory model that decodes what it receives. These are the opcode and address actually shifted out, the exact count of data clocks, the byte values and their index order, the strap capture at reset, and the ignored mid-transfer start.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_LAG,
      ST_GAP
   } cfg_state_t;

   localparam logic [7:0] READ_OPCODE = 8'h03;
endpackage

// File: rtl/cfgrom_phase.sv
// Serial clock phase generator: HALF cycles low, then HALF cycles high.
module cfgrom_phase #(
   parameter int HALF = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise,
   output logic fall
);
   localparam int PER = 2 * HALF;
   localparam int PW  = (PER > 2) ? $clog2(PER) : 1;

   logic [PW-1:0] ph;

   assign rise = run && (ph == PW'(HALF - 1));
   assign fall = run && (ph == PW'(PER - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= '0;
         sck <= 1'b0;
      end else if (!run || fall) begin
         ph  <= '0;
         sck <= 1'b0;
      end else begin
         ph <= ph + 1'b1;
         if (rise) sck <= 1'b1;
      end
   end
endmodule

// File: rtl/cfgrom_delay.sv
// Loadable down-counter used for the chip-select intervals.
module cfgrom_delay #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt;

   assign zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/cfgrom_rx.sv
// Assembles incoming bits MSB first into bytes.
module cfgrom_rx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       sample,
   input  logic       bit_in,
   output logic [7:0] byte_out,
   output logic       complete
);
   logic [6:0] sr;
   logic [2:0] bc;

   assign complete = sample && (bc == 3'd7);
   assign byte_out = {sr, bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
         bc <= '0;
      end else if (clear) begin
         bc <= '0;
      end else if (sample) begin
         sr <= {sr[5:0], bit_in};
         bc <= bc + 1'b1;
      end
   end
endmodule

// File: rtl/cfgrom_reader.sv
module cfgrom_reader
   import cfgrom_pkg::*;
#(
   parameter int CLK_HALF    = 6,
   parameter int CS_LEAD_CYC = 6,
   parameter int CS_LAG_CYC  = 6,
   parameter int CS_IDLE_CYC = 12,
   parameter int ADDR_W      = 24,
   parameter int NARROW_W    = 16,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_use_rom,
   input  logic              strap_wide_addr,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              busy,
   output logic              done,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic [CNT_W-1:0]  rd_index,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int HDR_WIDE   = 8 + ADDR_W;
   localparam int HDR_NARROW = 8 + NARROW_W;
   localparam int HDR_CW     = $clog2(HDR_WIDE + 1);
   localparam int BIT_W      = CNT_W + 4;
   localparam int TMR_MAX    = (CS_IDLE_CYC > CS_LEAD_CYC) ?
                               ((CS_IDLE_CYC > CS_LAG_CYC) ? CS_IDLE_CYC : CS_LAG_CYC) :
                               ((CS_LEAD_CYC > CS_LAG_CYC) ? CS_LEAD_CYC : CS_LAG_CYC);
   localparam int TMR_W      = $clog2(TMR_MAX + 1);

   generate
      if (CLK_HALF < 1 || CS_LEAD_CYC < 1 || CS_LAG_CYC < 1 || CS_IDLE_CYC < 1) begin : g_bad_timing
         $error("cfgrom_reader: every interval must be at least one cycle");
      end
      if (NARROW_W < 8 || NARROW_W >= ADDR_W || ADDR_W > 32) begin : g_bad_addr
         $error("cfgrom_reader: need 8 <= NARROW_W < ADDR_W <= 32");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("cfgrom_reader: CNT_W too small for the header count");
      end
   endgenerate

   // Straps are sampled only while reset is asserted.
   logic use_rom_q, wide_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         use_rom_q <= strap_use_rom;
         wide_q    <= strap_wide_addr;
      end
   end

   cfg_state_t          state;
   logic [HDR_WIDE-1:0] tx_sr;
   logic [HDR_CW-1:0]   hdr_left;
   logic [BIT_W-1:0]    bits_left;
   logic [CNT_W-1:0]    byte_idx;

   logic             run, rise, fall;
   logic             tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic             rx_sample, rx_complete;
   logic [7:0]       rx_byte;
   logic             go;

   assign go        = (state == ST_IDLE) && start && use_rom_q && (byte_count != '0);
   assign run       = (state == ST_SHIFT);
   assign rx_sample = rise && (hdr_left == '0);
   assign spi_mosi  = tx_sr[HDR_WIDE-1];

   cfgrom_phase #(.HALF(CLK_HALF)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run), .sck(spi_sck), .rise(rise), .fall(fall)
   );

   cfgrom_delay #(.W(TMR_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
   );

   cfgrom_rx u_rx (
      .clk(clk), .rst_n(rst_n), .clear(go), .sample(rx_sample), .bit_in(spi_miso),
      .byte_out(rx_byte), .complete(rx_complete)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_IDLE:  if (go) begin
                      tmr_load = 1'b1;
                      tmr_val  = TMR_W'(CS_LEAD_CYC - 1);
                   end
         ST_SHIFT: if (fall && bits_left == BIT_W'(1)) begin
                      tmr_load = 1'b1;
                      tmr_val  = TMR_W'(CS_LAG_CYC - 1);
                   end
         ST_LAG:   if (tmr_zero) begin
                      tmr_load = 1'b1;
                      tmr_val  = TMR_W'(CS_IDLE_CYC - 1);
                   end
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         spi_cs_n  <= 1'b1;
         busy      <= 1'b0;
         done      <= 1'b0;
         tx_sr     <= '0;
         hdr_left  <= '0;
         bits_left <= '0;
         byte_idx  <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         rd_index  <= '0;
      end else begin
         done     <= 1'b0;
         rd_valid <= rx_complete;
         if (rx_complete) begin
            rd_data  <= rx_byte;
            rd_index <= byte_idx;
            byte_idx <= byte_idx + 1'b1;
         end
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  spi_cs_n <= 1'b0;
                  busy     <= 1'b1;
                  byte_idx <= '0;
                  state    <= ST_LEAD;
                  if (wide_q) begin
                     tx_sr     <= {READ_OPCODE, base_addr};
                     hdr_left  <= HDR_CW'(HDR_WIDE);
                     bits_left <= BIT_W'({byte_count, 3'b000}) + BIT_W'(HDR_WIDE);
                  end else begin
                     tx_sr     <= {READ_OPCODE, base_addr[NARROW_W-1:0], {(ADDR_W-NARROW_W){1'b0}}};
                     hdr_left  <= HDR_CW'(HDR_NARROW);
                     bits_left <= BIT_W'({byte_count, 3'b000}) + BIT_W'(HDR_NARROW);
                  end
               end else if (start) begin
                  done <= 1'b1;
               end
            end
            ST_LEAD: if (tmr_zero) state <= ST_SHIFT;
            ST_SHIFT: begin
               if (fall) begin
                  tx_sr     <= {tx_sr[HDR_WIDE-2:0], 1'b0};
                  bits_left <= bits_left - 1'b1;
                  if (hdr_left != '0) hdr_left <= hdr_left - 1'b1;
                  if (bits_left == BIT_W'(1)) state <= ST_LAG;
               end
            end
            ST_LAG: if (tmr_zero) begin
               spi_cs_n <= 1'b1;
               state    <= ST_GAP;
            end
            ST_GAP: if (tmr_zero) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfgrom_reader_chk.sv
module cfgrom_reader_chk #(
   parameter int CLK_HALF    = 6,
   parameter int CS_LEAD_CYC = 6,
   parameter int CS_LAG_CYC  = 6,
   parameter int CS_IDLE_CYC = 12
) (
   input logic clk,
   input logic rst_n,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi,
   input logic busy,
   input logic done,
   input logic rd_valid
);
   logic       sck_d;
   logic [7:0] run_len;
   logic [7:0] csh_len;
   logic [7:0] csl_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         run_len <= '0;
         csh_len <= 8'(CS_IDLE_CYC);
         csl_len <= '0;
      end else begin
         sck_d   <= spi_sck;
         run_len <= (spi_sck != sck_d) ? 8'd1 : ((run_len == 8'hFF) ? run_len : run_len + 8'd1);
         csh_len <= !spi_cs_n ? 8'd0 : ((csh_len == 8'hFF) ? csh_len : csh_len + 8'd1);
         csl_len <= spi_cs_n ? 8'd0 : ((csl_len == 8'hFF) ? csl_len : csl_len + 8'd1);
      end
   end

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sck); // R2
   AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) spi_sck |-> $stable(spi_mosi)); // R2
   AST_SCK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n) (!spi_sck && sck_d) |-> run_len == 8'(CLK_HALF)); // R3
   AST_SCK_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n) (spi_sck && !sck_d) |-> run_len >= 8'(CLK_HALF)); // R3
   AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) (spi_sck && !sck_d) |-> csl_len >= 8'(CS_LEAD_CYC)); // R4
   AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_cs_n) |-> (!sck_d && run_len >= 8'(CS_LAG_CYC))); // R4
   AST_CS_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(spi_cs_n) |-> csh_len >= 8'(CS_IDLE_CYC)); // R4
   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> busy); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
   AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> spi_cs_n); // R8
endmodule

bind cfgrom_reader cfgrom_reader_chk #(
   .CLK_HALF(CLK_HALF), .CS_LEAD_CYC(CS_LEAD_CYC), .CS_LAG_CYC(CS_LAG_CYC), .CS_IDLE_CYC(CS_IDLE_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
   .busy(busy), .done(done), .rd_valid(rd_valid)
);

// File: tb/tb_cfgrom_reader.sv
module tb_cfgrom_reader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_use_rom = 1'b1;
   logic        strap_wide_addr = 1'b1;
   logic        start = 1'b0;
   logic [23:0] base_addr = '0;
   logic [15:0] byte_count = '0;
   logic        busy, done, rd_valid;
   logic [7:0]  rd_data;
   logic [15:0] rd_index;
   logic        spi_cs_n, spi_sck, spi_mosi;
   logic        spi_miso = 1'b0;

   always #4 clk = ~clk;

   cfgrom_reader dut (
      .clk(clk), .rst_n(rst_n), .strap_use_rom(strap_use_rom), .strap_wide_addr(strap_wide_addr),
      .start(start), .base_addr(base_addr), .byte_count(byte_count), .busy(busy), .done(done),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rom_byte(input logic [23:0] a);
      return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'hA5;
   endfunction

   // Memory model on the serial bus
   int          hdr_bits = 32;
   int          s_bits = 0;
   int          rises = 0;
   int          cs_falls = 0;
   logic [7:0]  s_cmd = '0;
   logic [23:0] s_addr = '0;

   always @(negedge spi_cs_n) begin
      s_bits = 0; s_cmd = '0; s_addr = '0; cs_falls++;
   end
   always @(posedge spi_sck) begin
      if (!spi_cs_n) begin
         if (s_bits < 8) s_cmd = {s_cmd[6:0], spi_mosi};
         else if (s_bits < hdr_bits) s_addr = {s_addr[22:0], spi_mosi};
         s_bits++;
      end
      rises++;
   end
   always @(negedge spi_sck) begin
      if (!spi_cs_n && s_bits >= hdr_bits) begin
         automatic int k = s_bits - hdr_bits;
         automatic logic [7:0] b = rom_byte(s_addr + 24'(k / 8));
         spi_miso = b[7 - (k % 8)];
      end
   end

   // Output monitor, sampled mid-cycle
   logic [7:0] got [64];
   int  nrx = 0, idx_bad = 0, hi_run = 0, hi_min = 999, hi_max = 0, lead = 0;
   int  cycles = 0, dones = 0;
   bit  seen_rise = 0, done_prev = 0, done_dbl = 0;

   always @(negedge clk) begin
      cycles++;
      if (rd_valid) begin
         if (nrx < 64) got[nrx] = rd_data;
         if (rd_index != 16'(nrx)) idx_bad++;
         nrx++;
      end
      if (spi_sck) hi_run++;
      else if (hi_run != 0) begin
         if (hi_run < hi_min) hi_min = hi_run;
         if (hi_run > hi_max) hi_max = hi_run;
         hi_run = 0;
      end
      if (spi_sck) seen_rise = 1;
      if (!spi_cs_n && !seen_rise) lead++;
      if (done) dones++;
      if (done && done_prev) done_dbl = 1;
      done_prev = done;
      if (cycles > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL R7 watchdog: actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic clear_mon();
      nrx = 0; idx_bad = 0; hi_min = 999; hi_max = 0; lead = 0; seen_rise = 0;
      rises = 0; cs_falls = 0; dones = 0; done_dbl = 0;
   endtask

   task automatic do_reset(input bit use_rom, input bit wide);
      @(negedge clk);
      rst_n = 1'b0; strap_use_rom = use_rom; strap_wide_addr = wide;
      hdr_bits = wide ? 32 : 24;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse_start(input logic [23:0] a, input logic [15:0] n);
      @(negedge clk);
      start = 1'b1; base_addr = a; byte_count = n;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin ok = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic check_xfer(input string tag, input bit wide, input logic [23:0] a, input int n);
      automatic logic [23:0] ea = wide ? a : {8'h00, a[15:0]};
      automatic int hb = wide ? 32 : 24;
      check_eq("R5", {tag, " opcode"}, s_cmd, 8'h03);
      check_eq("R5", {tag, " address"}, s_addr, ea);
      check_eq("R6", {tag, " clock count"}, rises, hb + 8 * n);
      check_eq("R6", {tag, " byte count"}, nrx, n);
      check_eq("R6", {tag, " index order errors"}, idx_bad, 0);
      for (int i = 0; i < n && i < 64; i++)
         check_eq("R6", {tag, " byte value"}, got[i], rom_byte(ea + 24'(i)));
   endtask

   typedef struct packed { logic wide; logic [23:0] addr; logic [15:0] cnt; } vec_t;
   localparam vec_t VEC [5] = '{
      '{1'b0, 24'h001234, 16'd4},
      '{1'b1, 24'hABCDEF, 16'd3},
      '{1'b1, 24'h00FFFE, 16'd5},
      '{1'b0, 24'hFF0010, 16'd2},
      '{1'b1, 24'h000000, 16'd1}
   };

   initial begin
      bit ok;
      // R1 reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R1", "cs_n in reset", spi_cs_n, 1);
      check_eq("R1", "sck in reset", spi_sck, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "busy/done/valid after reset", {busy, done, rd_valid}, 0);

      // Vector table
      foreach (VEC[v]) begin
         do_reset(1'b1, VEC[v].wide);
         clear_mon();
         pulse_start(VEC[v].addr, VEC[v].cnt);
         check_eq("R7", "busy after start", busy, 1);
         wait_done(ok);
         check_eq("R7", "done seen", ok, 1);
         check_eq("R7", "busy low with done", busy, 0);
         @(negedge clk);
         check_eq("R7", "done single pulse", done_dbl, 0);
         check_xfer("vec", VEC[v].wide, VEC[v].addr, int'(VEC[v].cnt));
         check_eq("R3", "sck high min", hi_min, 6);
         check_eq("R3", "sck high max", hi_max, 6);
         check_eq("R4", "cs setup at least 6", (lead >= 6), 1);
         check_eq("R2", "idle sck low, cs high", {spi_sck, spi_cs_n}, 2'b01);
      end

      // R8: no memory fitted
      do_reset(1'b0, 1'b1);
      clear_mon();
      pulse_start(24'h000100, 16'd4);
      check_eq("R8", "done next cycle", done, 1);
      repeat (30) @(negedge clk);
      check_eq("R8", "no cs fall", cs_falls, 0);
      check_eq("R8", "no sck edge", rises, 0);

      // R9: zero count
      do_reset(1'b1, 1'b1);
      clear_mon();
      pulse_start(24'h000200, 16'd0);
      check_eq("R9", "done next cycle", done, 1);
      repeat (30) @(negedge clk);
      check_eq("R9", "no bus activity", cs_falls + rises, 0);

      // R10: straps changed after reset are ignored
      do_reset(1'b1, 1'b0);
      strap_wide_addr = 1'b1; strap_use_rom = 1'b0;
      clear_mon();
      pulse_start(24'h5A3C81, 16'd2);
      wait_done(ok);
      @(negedge clk);
      check_eq("R10", "transfer still ran", cs_falls, 1);
      check_xfer("R10", 1'b0, 24'h5A3C81, 2);

      // R11: start while busy
      do_reset(1'b1, 1'b1);
      clear_mon();
      pulse_start(24'h012345, 16'd3);
      repeat (60) @(negedge clk);
      start = 1'b1; base_addr = 24'hFFFFFF; byte_count = 16'd9;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      repeat (40) @(negedge clk);
      check_eq("R11", "one transfer", cs_falls, 1);
      check_eq("R11", "one done", dones, 1);
      check_xfer("R11", 1'b1, 24'h012345, 3);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule